// File: doc/BRIEF.md
# Generator Address Marshal Buffer

A per-core buffer that collects the cache-block addresses written by stores marked as generators. When the core later issues a marshal command that names a destination, the buffer sends every collected block address to a push engine, one request per block, each tagged with that destination. The command is meant to come just before the next code segment starts, so the consumer core's cache has the blocks by the time it needs them. The cache data transfer is outside this block, and so is the mapping from segment to core.

Each block is recorded once, in the order of its first store. A byte address is reduced to its 64-byte block, and a store to a block that is already recorded leaves the buffer unchanged. Capacity is 16 blocks. Further new blocks are dropped and a sticky overflow flag is raised. During a drain the buffer refuses both generator stores and new commands. When the last push has been taken it empties itself, clears the flag and accepts input again.

The stores, the command and the pushes use valid/ready. A generator store or command counts as taken on a clock edge where its valid and its ready are both high. A push request is taken on an edge where `push_valid` and `push_ready` are both high. Once `push_valid` is raised, the request does not change and is not withdrawn until it is taken.

Top module: `gen_marshal_buf`

## Requirements
- R1: After reset, `gen_ready` and `mcmd_ready` are 1, and `push_valid` and `overflow` are 0.
- R2: A taken generator store records the block address `gen_addr[47:6]`. The low six bits play no part. Blocks are pushed in the order in which they were first recorded.
- R3: A store to a block that is already recorded adds no entry, so the block is pushed only once.
- R4: The buffer holds up to 16 distinct blocks. A new block that arrives while 16 are held is dropped and sets `overflow`, which stays at 1 until a drain completes. A store to a block that is already held, made while the buffer is full, does not set `overflow`.
- R5: A taken marshal command produces one push per recorded block. Each push carries the command's `mcmd_dest` on `push_dest`. `push_valid` can first be high in the cycle after the command is taken.
- R6: While `push_valid` is 1 and `push_ready` is 0, `push_valid`, `push_blk` and `push_dest` hold their values. While `push_ready` stays at 1, one push is taken per cycle.
- R7: From the edge that takes a command until the edge that takes the last push, `gen_ready` and `mcmd_ready` are 0. After that edge the buffer is empty, `overflow` is 0 and both ready signals are 1. A store held off during the drain is taken once the drain is over and goes into the next buffer.
- R8: A marshal command taken while the buffer is empty produces no push. The buffer refuses input for exactly one cycle.
- R9: A generator store and a command taken on the same edge both take effect, and that store is included in the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_valid | input | 1 | Generator store address is present |
| gen_ready | output | 1 | Buffer can take a generator store |
| gen_addr | input | 48 | Physical byte address written by the store |
| mcmd_valid | input | 1 | Marshal command is present |
| mcmd_ready | output | 1 | Buffer can take a command |
| mcmd_dest | input | 6 | Destination core or segment of the command |
| push_valid | output | 1 | Push request is present |
| push_ready | input | 1 | Push engine takes the request |
| push_blk | output | 42 | Block address to push |
| push_dest | output | 6 | Destination of the push |
| overflow | output | 1 | Sticky flag: a new block was dropped |

## Verification
Distinct blocks, with the low address bits varied inside each block, show that capture works on blocks and keeps the order of arrival. Repeated stores to one block, some with a different byte offset, separate correct suppression from double recording. A fill to 16 followed by a repeated block and then new blocks locates the exact point where `overflow` rises. Drains run with `push_ready` held high, with `push_ready` toggling, with an empty buffer, with a store held off during the drain and with a store arriving on the same edge as the command. Together these pin down stalling, tagging, the moment the buffer clears and the handling of stores at the drain boundaries.

// File: rtl/gmb_pkg.sv
package gmb_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_st_t;
endpackage

// File: rtl/gmb_entry_store.sv
module gmb_entry_store #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 42,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [BLK_W-1:0] cap_blk,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count,
  output logic [BLK_W-1:0] rd_blk,
  output logic             overflow
);
  logic [BLK_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0] live_v;
  logic [DEPTH-1:0] match_v;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic             hit;
  logic             full;
  logic             do_write;

  // One comparator per slot: a slot is live when its index is below the fill count.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign live_v[i]  = (CNT_W'(i) < count_q);
    assign match_v[i] = live_v[i] && (ent_q[i] == cap_blk);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (do_write && (count_q == CNT_W'(i))) begin
        ent_q[i] <= cap_blk;
      end
    end
  end

  assign hit      = |match_v;
  assign full     = (count_q == CNT_W'(DEPTH));
  assign do_write = cap_en && !hit && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (clr) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_write) begin
        count_q <= count_q + CNT_W'(1);
      end
      if (cap_en && !hit && full) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign count    = count_q;
  assign rd_blk   = ent_q[rd_idx];
  assign overflow = ovf_q;

  // R2: a new block adds exactly one entry.
  p_new_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !hit && !full) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R3: a repeated block leaves the fill level alone.
  p_dup_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && hit) |=> $stable(count_q));

  // R4: a new block on a full buffer is dropped and flagged.
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !hit && full) |=> (ovf_q && (count_q == CNT_W'(DEPTH))));

  // R4: the fill level never exceeds the capacity.
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= CNT_W'(DEPTH)));

  // R7: capture and clear never collide.
  p_cap_clr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_en && clr));
endmodule

// File: rtl/gmb_drain_seq.sv
module gmb_drain_seq
  import gmb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DEST_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DEST_W-1:0] cmd_dest,
  input  logic [CNT_W-1:0]  count,
  input  logic              push_ready,
  output logic              busy,
  output logic              push_valid,
  output logic [DEST_W-1:0] push_dest,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              clr
);
  drain_st_t         st_q;
  logic [IDX_W-1:0]  rd_q;
  logic [DEST_W-1:0] dest_q;
  logic              fire;
  logic              last_fire;
  logic              empty_done;

  assign busy       = (st_q == ST_DRAIN);
  assign push_valid = busy && (CNT_W'(rd_q) < count);
  assign fire       = push_valid && push_ready;
  assign last_fire  = fire && ((CNT_W'(rd_q) + CNT_W'(1)) == count);
  assign empty_done = busy && (count == '0);
  assign clr        = last_fire || empty_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rd_q   <= '0;
      dest_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            st_q   <= ST_DRAIN;
            rd_q   <= '0;
            dest_q <= cmd_dest;
          end
        end
        ST_DRAIN: begin
          if (clr) begin
            st_q <= ST_IDLE;
            rd_q <= '0;
          end else if (fire) begin
            rd_q <= rd_q + IDX_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign push_dest = dest_q;
  assign rd_idx    = rd_q;

  // R5: a taken command starts the drain at the first slot with its destination.
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> (busy && (rd_q == '0) && (push_dest == $past(cmd_dest))));

  // R6: a stalled request holds its contents.
  p_push_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(rd_q) && $stable(push_dest)));

  // R7: leaving the drain leaves the buffer empty.
  p_finish_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (count == '0));
endmodule

// File: rtl/gen_marshal_buf.sv
module gen_marshal_buf #(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 48,
  parameter int BLK_BYTES = 64,
  parameter int DEST_W    = 6,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFF_W,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_valid,
  output logic              gen_ready,
  input  logic [ADDR_W-1:0] gen_addr,
  input  logic              mcmd_valid,
  output logic              mcmd_ready,
  input  logic [DEST_W-1:0] mcmd_dest,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BLK_W-1:0]  push_blk,
  output logic [DEST_W-1:0] push_dest,
  output logic              overflow
);
  logic             busy;
  logic             cap_en;
  logic             clr;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] rd_idx;
  logic             unused_off;

  assign unused_off = ^gen_addr[OFF_W-1:0];
  assign gen_ready  = !busy;
  assign mcmd_ready = !busy;
  assign cap_en     = gen_valid && !busy;

  gmb_entry_store #(
    .DEPTH (DEPTH),
    .BLK_W (BLK_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_blk  (gen_addr[ADDR_W-1:OFF_W]),
    .clr      (clr),
    .rd_idx   (rd_idx),
    .count    (count),
    .rd_blk   (push_blk),
    .overflow (overflow)
  );

  gmb_drain_seq #(
    .DEPTH  (DEPTH),
    .DEST_W (DEST_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (mcmd_valid),
    .cmd_dest   (mcmd_dest),
    .count      (count),
    .push_ready (push_ready),
    .busy       (busy),
    .push_valid (push_valid),
    .push_dest  (push_dest),
    .rd_idx     (rd_idx),
    .clr        (clr)
  );

  // R6: the pushed block address holds while stalled.
  p_blk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> $stable(push_blk));
endmodule

// File: tb/tb_gen_marshal_buf.sv
module tb_gen_marshal_buf;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        gen_valid, gen_ready, mcmd_valid, mcmd_ready;
  logic [47:0] gen_addr;
  logic [5:0]  mcmd_dest, push_dest;
  logic        push_valid, push_ready, overflow;
  logic [41:0] push_blk;

  always #4 clk = ~clk;

  gen_marshal_buf dut (
    .clk(clk), .rst_n(rst_n),
    .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_addr(gen_addr),
    .mcmd_valid(mcmd_valid), .mcmd_ready(mcmd_ready), .mcmd_dest(mcmd_dest),
    .push_valid(push_valid), .push_ready(push_ready), .push_blk(push_blk),
    .push_dest(push_dest), .overflow(overflow)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [41:0] exp_blk [32];
  int          exp_n = 0;
  logic        exp_ovf = 1'b0;
  logic [41:0] got_blk [64];
  logic [5:0]  got_dest [64];
  int          got_n = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Push monitor: samples just after the bench drives, before the edge.
  always begin
    @(negedge clk);
    #1;
    if (push_valid && push_ready && got_n < 64) begin
      got_blk[got_n]  = push_blk;
      got_dest[got_n] = push_dest;
      got_n++;
    end
  end

  task automatic model_gen(logic [47:0] a);
    logic [41:0] b;
    bit found;
    b = a[47:6];
    found = 0;
    for (int i = 0; i < exp_n; i++) if (exp_blk[i] == b) found = 1;
    if (!found) begin
      if (exp_n < DEPTH) begin
        exp_blk[exp_n] = b;
        exp_n++;
      end else begin
        exp_ovf = 1'b1;
      end
    end
  endtask

  task automatic gen_one(logic [47:0] a);
    gen_valid = 1'b1;
    gen_addr  = a;
    @(negedge clk);
    gen_valid = 1'b0;
    model_gen(a);
  endtask

  task automatic compare_pushes(string req, logic [5:0] dest);
    chk(req, "push count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(req, "push block", 64'(got_blk[i]), 64'(exp_blk[i]));
      chk(req, "push dest", 64'(got_dest[i]), 64'(dest));
    end
  endtask

  task automatic run_drain(string req, logic [5:0] dest, bit toggle, bit with_gen, logic [47:0] a);
    int cyc;
    bit hold_pend;
    logic [41:0] h_blk;
    logic [5:0]  h_dest;
    got_n      = 0;
    mcmd_valid = 1'b1;
    mcmd_dest  = dest;
    if (with_gen) begin
      gen_valid = 1'b1;
      gen_addr  = a;
      model_gen(a);
    end
    @(negedge clk);
    mcmd_valid = 1'b0;
    gen_valid  = 1'b0;
    cyc = 0;
    hold_pend = 0;
    chk("R7", "gen_ready in drain", 64'(gen_ready), 64'(0));
    chk("R7", "mcmd_ready in drain", 64'(mcmd_ready), 64'(0));
    while (!gen_ready && cyc < 200) begin
      if (hold_pend) begin
        chk("R6", "stalled valid", 64'(push_valid), 64'(1));
        chk("R6", "stalled block", 64'(push_blk), 64'(h_blk));
        chk("R6", "stalled dest", 64'(push_dest), 64'(h_dest));
      end
      push_ready = toggle ? cyc[0] : 1'b1;
      hold_pend  = push_valid && !push_ready;
      h_blk      = push_blk;
      h_dest     = push_dest;
      @(negedge clk);
      cyc++;
    end
    push_ready = 1'b1;
    compare_pushes(req, dest);
    chk("R7", "overflow after drain", 64'(overflow), 64'(0));
    chk("R7", "gen_ready after drain", 64'(gen_ready), 64'(1));
    chk("R7", "mcmd_ready after drain", 64'(mcmd_ready), 64'(1));
    if (!toggle) chk("R6", "drain cycles", 64'(cyc), 64'(exp_n));
    exp_n = 0;
    exp_ovf = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    gen_valid = 1'b0; gen_addr = '0;
    mcmd_valid = 1'b0; mcmd_dest = '0;
    push_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "gen_ready", 64'(gen_ready), 64'(1));
    chk("R1", "mcmd_ready", 64'(mcmd_ready), 64'(1));
    chk("R1", "push_valid", 64'(push_valid), 64'(0));
    chk("R1", "overflow", 64'(overflow), 64'(0));
  endtask

  task automatic t_basic();
    gen_one(48'h0000_1234_5678);
    gen_one(48'h0000_0000_0040);
    gen_one(48'hFFFF_FFFF_FFFF);
    run_drain("R2 R5", 6'd5, 1'b0, 1'b0, '0);
  endtask

  task automatic t_dup();
    gen_one(48'h0000_0ABC_0000);
    gen_one(48'h0000_0ABC_0008);
    gen_one(48'h0000_0ABC_0100);
    gen_one(48'h0000_0ABC_003F);
    chk("R3", "model entries", 64'(exp_n), 64'(2));
    run_drain("R3", 6'd12, 1'b0, 1'b0, '0);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 5; i++) gen_one(48'h0002_0000_0000 + 48'(i * 448));
    run_drain("R6", 6'd33, 1'b1, 1'b0, '0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) gen_one(48'h0000_7000_0000 + 48'(i * 64) + 48'(i));
    chk("R4", "overflow at capacity", 64'(overflow), 64'(0));
    gen_one(48'h0000_7000_0005);
    chk("R4", "overflow after full dup", 64'(overflow), 64'(0));
    gen_one(48'h0000_8000_0000);
    chk("R4", "overflow after drop", 64'(overflow), 64'(1));
    gen_one(48'h0000_9000_0000);
    chk("R4", "overflow sticky", 64'(overflow), 64'(exp_ovf));
    run_drain("R4", 6'd63, 1'b0, 1'b0, '0);
  endtask

  task automatic t_held();
    int cyc;
    gen_one(48'h0000_0100_0000);
    gen_one(48'h0000_0200_0000);
    got_n = 0;
    mcmd_valid = 1'b1;
    mcmd_dest  = 6'd9;
    @(negedge clk);
    mcmd_valid = 1'b0;
    gen_valid  = 1'b1;
    gen_addr   = 48'h0000_0300_0000;
    chk("R7", "store held off", 64'(gen_ready), 64'(0));
    cyc = 0;
    while (!gen_ready && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    compare_pushes("R7", 6'd9);
    @(negedge clk);
    gen_valid = 1'b0;
    exp_n = 0;
    model_gen(48'h0000_0300_0000);
    run_drain("R7", 6'd10, 1'b0, 1'b0, '0);
  endtask

  task automatic t_empty();
    got_n = 0;
    mcmd_valid = 1'b1;
    mcmd_dest  = 6'd3;
    @(negedge clk);
    mcmd_valid = 1'b0;
    chk("R8", "busy one cycle", 64'(gen_ready), 64'(0));
    chk("R8", "no push", 64'(push_valid), 64'(0));
    @(negedge clk);
    chk("R8", "ready again", 64'(gen_ready), 64'(1));
    chk("R8", "push count", 64'(got_n), 64'(0));
  endtask

  task automatic t_same_cycle();
    gen_one(48'h0000_4000_0080);
    run_drain("R9", 6'd21, 1'b0, 1'b1, 48'h0000_5000_00C0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_dup();
    t_backpressure();
    t_overflow();
    t_held();
    t_empty();
    t_same_cycle();
    summary();
    $finish;
  end
endmodule